// File: doc/BRIEF.md
# Two-Antenna Diversity Selector

This block chooses between two receive antennas during acquisition. Each antenna is given a dwell of a fixed number of symbols. Antenna 0 dwells first and antenna 1 second. During each dwell the block gathers two quality figures for that antenna. The first is the sum of the per-symbol phase-variance terms that the demodulator supplies. The second is a sidelobe energy sum that the block builds itself from the correlator magnitude stream. This stream carries two samples per chip, and the bench feeds them one per cycle.

A select input picks which figure decides. The antenna with the smaller figure wins, and antenna 0 wins a tie. The output is the antenna select together with a one-cycle strobe that marks the decision. In single-antenna mode only the antenna-0 dwell runs, and the block then reports antenna 0 without any comparison.

For the sidelobe figure, the sample index counts up from 0 at the first sample of each symbol. The peak index marks the on-time sample. The three-sample core at offsets -1, 0 and +1 from the peak is left out. The three samples beyond the core on each side, at offsets ±2, ±3 and ±4, are added in.

Top module: `ant_div_sel`

## Requirements
- R1: After reset, `ant_sel` is 0 and `dec_valid` is 0.
- R2: A `dwell_start` pulse clears both antennas' metrics and begins the antenna-0 dwell. From the next cycle `ant_sel` is 0. A pulse that arrives mid-dwell restarts the whole sequence, and the values gathered before it are discarded.
- R3: In dual mode, after `DWELL_SYMS` `sym_end` strobes in the antenna-0 dwell, `ant_sel` becomes 1 on the next cycle and the antenna-1 dwell begins. `ant_sel` stays 1 for the whole of that dwell.
- R4: With `metric_sel`=0, the decision compares the sums of `sq2_in` taken at each `sym_end` of each dwell. The antenna with the smaller sum is chosen.
- R5: With `metric_sel`=1, the decision compares the sums of `samp_mag` over the samples whose index lies at offset ±2, ±3 or ±4 from `peak_idx`. The index is 0 on the sample flagged `samp_sof` and rises by 1 with each `samp_valid`. The smaller sum wins.
- R6: Samples at offsets -1, 0 and +1, and samples at offsets beyond ±4, add nothing to the sidelobe sum.
- R7: When the two antennas' metrics are equal, antenna 0 is chosen.
- R8: `dec_valid` is a single-cycle pulse. It appears on the cycle after the final `sym_end` of the last dwell, and `ant_sel` already shows the chosen antenna in that cycle.
- R9: With `single_ant`=1, `dec_valid` pulses on the cycle after the final `sym_end` of the antenna-0 dwell, with `ant_sel`=0. No second dwell follows.
- R10: A sample that arrives in the same cycle as the final `sym_end` of a dwell counts toward that closing dwell's metric.
- R11: Samples and `sym_end` strobes that arrive outside a dwell leave `ant_sel` unchanged and produce no `dec_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dwell_start | input | 1 | Pulse that begins the antenna-0 dwell |
| single_ant | input | 1 | 1 = single-antenna mode |
| metric_sel | input | 1 | 0 = phase-variance sum decides, 1 = sidelobe sum decides |
| samp_valid | input | 1 | Correlator magnitude sample present |
| samp_sof | input | 1 | Marks the first sample of a symbol |
| samp_mag | input | MAG_W | Correlator magnitude sample |
| peak_idx | input | IDX_W | Index of the on-time sample in the current symbol |
| sym_end | input | 1 | End-of-symbol strobe |
| sq2_in | input | SQ2_W | Phase-variance term for the symbol, taken with `sym_end` |
| ant_sel | output | 1 | Selected antenna |
| dec_valid | output | 1 | One-cycle decision strobe |

## Verification
The final `sym_end` of a dwell can fall in the same cycle as a correlator sample, and in that cycle the block closes the dwell and accumulates at once. The bench provokes this by placing the last sample of every symbol together with its `sym_end`, with the peak positioned so that this sample is a sidelobe tap. It then judges the decision against sums that include that sample. A `dwell_start` that lands mid-dwell is a second collision between restart and accumulation. The bench judges it by whether the decision depends only on the symbols that follow the restart.

// File: rtl/ant_div_sel.sv
module ant_div_sel #(
  parameter int MAG_W      = 8,
  parameter int SQ2_W      = 12,
  parameter int SYM_LEN    = 22,
  parameter int DWELL_SYMS = 16,
  parameter int CORE_HALF  = 1,
  parameter int SIDE_N     = 3,
  parameter int IDX_W      = $clog2(SYM_LEN) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dwell_start,
  input  logic             single_ant,
  input  logic             metric_sel,
  input  logic             samp_valid,
  input  logic             samp_sof,
  input  logic [MAG_W-1:0] samp_mag,
  input  logic [IDX_W-1:0] peak_idx,
  input  logic             sym_end,
  input  logic [SQ2_W-1:0] sq2_in,
  output logic             ant_sel,
  output logic             dec_valid
);

  localparam int CNT_W  = $clog2(DWELL_SYMS + 1);
  localparam int ACC2_W = SQ2_W + $clog2(DWELL_SYMS + 1);
  localparam int ACC3_W = MAG_W + $clog2(2 * SIDE_N * DWELL_SYMS + 1);
  localparam int CMP_W  = (ACC2_W > ACC3_W) ? ACC2_W : ACC3_W;
  localparam logic [IDX_W:0]   OFF_LO = (IDX_W + 1)'(CORE_HALF + 1);
  localparam logic [IDX_W:0]   OFF_HI = (IDX_W + 1)'(CORE_HALF + SIDE_N);
  localparam logic [CNT_W-1:0] LAST_SYM = CNT_W'(DWELL_SYMS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DW0, ST_DW1} st_t;
  st_t state;

  logic [IDX_W-1:0]  idx_cnt;
  logic [CNT_W-1:0]  sym_cnt;
  logic [ACC2_W-1:0] acc2_0, acc2_1;
  logic [ACC3_W-1:0] acc3_0, acc3_1;

  logic in_dwell;
  assign in_dwell = (state != ST_IDLE);

  logic [IDX_W-1:0] idx_now;
  logic [IDX_W:0]   off_raw, off_abs;
  logic             is_side;
  assign idx_now = samp_sof ? '0 : idx_cnt;
  assign off_raw = {1'b0, idx_now} - {1'b0, peak_idx};
  assign off_abs = off_raw[IDX_W] ? (~off_raw + 1'b1) : off_raw;
  assign is_side = (off_abs >= OFF_LO) && (off_abs <= OFF_HI);

  logic [ACC3_W-1:0] add3, nxt3;
  logic [ACC2_W-1:0] add2, nxt2;
  assign add3 = (in_dwell && samp_valid && is_side) ? ACC3_W'(samp_mag) : '0;
  assign add2 = (in_dwell && sym_end) ? ACC2_W'(sq2_in) : '0;
  assign nxt3 = ((state == ST_DW1) ? acc3_1 : acc3_0) + add3;
  assign nxt2 = ((state == ST_DW1) ? acc2_1 : acc2_0) + add2;

  logic last_sym;
  assign last_sym = in_dwell && sym_end && (sym_cnt == LAST_SYM);

  logic [CMP_W-1:0] m0, m1;
  logic             pick1;
  assign m0    = metric_sel ? CMP_W'(acc3_0) : CMP_W'(acc2_0);
  assign m1    = metric_sel ? CMP_W'(nxt3)   : CMP_W'(nxt2);
  assign pick1 = (m1 < m0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_cnt <= '0;
    end else if (samp_valid) begin
      idx_cnt <= idx_now + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ant_sel   <= 1'b0;
      dec_valid <= 1'b0;
      sym_cnt   <= '0;
      acc2_0    <= '0;
      acc2_1    <= '0;
      acc3_0    <= '0;
      acc3_1    <= '0;
    end else begin
      dec_valid <= 1'b0;
      if (dwell_start) begin
        state   <= ST_DW0;
        ant_sel <= 1'b0;
        sym_cnt <= '0;
        acc2_0  <= '0;
        acc2_1  <= '0;
        acc3_0  <= '0;
        acc3_1  <= '0;
      end else if (in_dwell) begin
        if (state == ST_DW0) begin
          acc2_0 <= nxt2;
          acc3_0 <= nxt3;
        end else begin
          acc2_1 <= nxt2;
          acc3_1 <= nxt3;
        end
        if (sym_end) sym_cnt <= last_sym ? '0 : sym_cnt + 1'b1;
        if (last_sym) begin
          if (state == ST_DW0 && !single_ant) begin
            state   <= ST_DW1;
            ant_sel <= 1'b1;
          end else begin
            state     <= ST_IDLE;
            dec_valid <= 1'b1;
            ant_sel   <= (state == ST_DW1) && pick1;
          end
        end
      end
    end
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dwell_start |=> (!ant_sel && !dec_valid && state == ST_DW0));

  assert_dwell1_ant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DW1) |-> ant_sel);

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(state == ST_DW0)) |-> !ant_sel);

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !dwell_start) |=> ($stable(ant_sel) && !dec_valid));

endmodule

// File: tb/tb_ant_div_sel.sv
module tb_ant_div_sel;
  localparam int CLK_PERIOD = 10;
  localparam int MAG_W = 8, SQ2_W = 12, SYM_LEN = 22, DWELL_SYMS = 16;
  localparam int IDX_W = $clog2(SYM_LEN) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dwell_start = 0, single_ant = 0, metric_sel = 0;
  logic samp_valid = 0, samp_sof = 0, sym_end = 0;
  logic [MAG_W-1:0] samp_mag = '0;
  logic [IDX_W-1:0] peak_idx = '0;
  logic [SQ2_W-1:0] sq2_in = '0;
  logic ant_sel, dec_valid;

  int n_tests = 0, n_fail = 0;
  longint e2[2], e3[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  ant_div_sel #(.MAG_W(MAG_W), .SQ2_W(SQ2_W), .SYM_LEN(SYM_LEN), .DWELL_SYMS(DWELL_SYMS)) dut (
    .clk(clk), .rst_n(rst_n), .dwell_start(dwell_start), .single_ant(single_ant),
    .metric_sel(metric_sel), .samp_valid(samp_valid), .samp_sof(samp_sof),
    .samp_mag(samp_mag), .peak_idx(peak_idx), .sym_end(sym_end), .sq2_in(sq2_in),
    .ant_sel(ant_sel), .dec_valid(dec_valid));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    dwell_start = 0; samp_valid = 0; samp_sof = 0; sym_end = 0; samp_mag = '0; sq2_in = '0;
  endtask

  function automatic bit side_tap(input int i, input int pk);
    int d = (i > pk) ? i - pk : pk - i;
    return (d >= 2) && (d <= 4);
  endfunction

  // mode 0 random, 1 all-zero, 2 energy only off the sidelobe taps (ant 0) or tiny sidelobes (ant 1)
  task automatic run_sym(input int ant, input int mode, input bit collide, input bit count);
    int m[SYM_LEN];
    int pk, s2;
    pk = collide ? SYM_LEN - 5 : 4 + $urandom_range(0, SYM_LEN - 9);
    s2 = (mode == 0) ? $urandom_range(0, 4095) : ((mode == 1) ? 100 : 0);
    for (int i = 0; i < SYM_LEN; i++) begin
      if (mode == 0) m[i] = $urandom_range(0, 255);
      else if (mode == 1) m[i] = 0;
      else if (ant == 0) m[i] = side_tap(i, pk) ? 0 : 255;
      else m[i] = side_tap(i, pk) ? 1 : 0;
      if (count && side_tap(i, pk)) e3[ant] += m[i];
    end
    if (count) e2[ant] += s2;
    for (int i = 0; i < SYM_LEN; i++) begin
      @(negedge clk);
      idle_inputs();
      samp_valid = 1; samp_sof = (i == 0); samp_mag = MAG_W'(m[i]); peak_idx = IDX_W'(pk);
      if (collide && i == SYM_LEN - 1) begin sym_end = 1; sq2_in = SQ2_W'(s2); end
    end
    if (!collide) begin
      @(negedge clk);
      idle_inputs();
      sym_end = 1; sq2_in = SQ2_W'(s2);
    end
  endtask

  task automatic run_decision(input bit msel, input bit single, input int mode0, input int mode1,
                              input bit collide, input bit restart);
    bit exp_ant;
    @(negedge clk);
    idle_inputs(); metric_sel = msel; single_ant = single; dwell_start = 1;
    e2[0] = 0; e2[1] = 0; e3[0] = 0; e3[1] = 0;
    if (restart) begin
      for (int s = 0; s < 5; s++) run_sym(0, 0, 0, 0);
      @(negedge clk);
      idle_inputs(); dwell_start = 1;
    end
    @(negedge clk);
    idle_inputs();
    check(ant_sel == 0 && dec_valid == 0, "R2 ant0 dwell after start", ant_sel, 0);
    for (int s = 0; s < DWELL_SYMS; s++) run_sym(0, mode0, collide, 1);
    @(negedge clk);
    if (single) begin
      check(dec_valid == 1 && ant_sel == 0, "R9 single-antenna decision", {dec_valid, ant_sel}, 2);
      idle_inputs();
      @(negedge clk);
      check(dec_valid == 0, "R8 strobe width", dec_valid, 0);
      return;
    end
    check(ant_sel == 1 && dec_valid == 0, "R3 switch to antenna 1", {dec_valid, ant_sel}, 1);
    idle_inputs();
    for (int s = 0; s < DWELL_SYMS; s++) begin
      run_sym(1, mode1, collide, 1);
      if (s == 0) check(ant_sel == 1, "R3 ant_sel held in dwell 1", ant_sel, 1);
    end
    exp_ant = msel ? (e3[1] < e3[0]) : (e2[1] < e2[0]);
    @(negedge clk);
    check(dec_valid == 1, "R8 decision strobe", dec_valid, 1);
    if (collide) check(ant_sel == exp_ant, "R10 colliding sample counted", ant_sel, exp_ant);
    else if (restart) check(ant_sel == exp_ant, "R2 restart discards old data", ant_sel, exp_ant);
    else if (msel) check(ant_sel == exp_ant, "R5 sidelobe decision", ant_sel, exp_ant);
    else check(ant_sel == exp_ant, "R4 phase variance decision", ant_sel, exp_ant);
    idle_inputs();
    @(negedge clk);
    check(dec_valid == 0 && ant_sel == exp_ant, "R8 single-cycle strobe", {dec_valid, ant_sel}, exp_ant);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    bit held, bad;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check(ant_sel == 0 && dec_valid == 0, "R1 reset state", {dec_valid, ant_sel}, 0);
    rst_n = 1;

    // R7: equal metrics under both selections keep antenna 0
    run_decision(0, 0, 1, 1, 0, 0);
    check(ant_sel == 0, "R7 tie on phase variance", ant_sel, 0);
    run_decision(1, 0, 1, 1, 0, 0);
    check(ant_sel == 0, "R7 tie on sidelobe sum", ant_sel, 0);

    // R6: core and far samples must not count
    run_decision(1, 0, 2, 2, 0, 0);
    check(ant_sel == 0, "R6 core and far samples excluded", ant_sel, 0);

    // R9: single antenna
    run_decision(1, 1, 0, 0, 0, 0);
    run_decision(0, 1, 0, 0, 1, 0);

    // R10: sample colliding with final sym_end
    for (int k = 0; k < 4; k++) run_decision(1, 0, 0, 0, 1, 0);

    // R2: restart mid-dwell
    run_decision(0, 0, 0, 0, 0, 1);
    run_decision(1, 0, 0, 0, 0, 1);

    // R11: traffic outside a dwell
    held = ant_sel; bad = 0;
    for (int s = 0; s < DWELL_SYMS + 2; s++) begin
      run_sym(0, 0, 0, 0);
      @(negedge clk);
      if (dec_valid || ant_sel != held) bad = 1;
    end
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    check(!bad && ant_sel == held && !dec_valid, "R11 idle traffic ignored", ant_sel, held);

    // R4/R5: random decisions
    for (int k = 0; k < 24; k++) run_decision(k[0], 0, 0, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule